// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block serialises clause-22 management transactions towards an Ethernet PHY. Software composes one complete 32-bit frame word with start code, operation, PHY address, register address, turnaround code and 16 data bits, and hands it over on a valid/ready command port. The controller first sends a run of preamble ones, then shifts the frame word out most significant bit first on the MDIO line, clocked by an MDC it derives from the system clock.

On a read the controller lets go of MDIO for the turnaround and data bits. It samples the PHY's answer on each rising MDC edge and writes it into the low 16 bits of the held frame word, which is always visible on `cmd_rdata`. A command is taken only while the management port is enabled and no frame is in flight; holding `cmd_valid` high while `cmd_ready` is low is back-pressure and changes nothing. `idle` reports completion.

The MDC ratio is chosen with `mdc_sel` (0, 1, 2, 3 give 8, 16, 32, 64). To keep MDC near or below 2.5 MHz, pick 8 for a bus clock under 20 MHz, 16 under 40 MHz, 32 under 80 MHz and 64 above that.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 1 and `cmd_rdata` is zero; whenever `idle` is 1, MDC stays low and MDIO is released.
- R2: `cmd_ready` equals `mgmt_en` AND `idle`; a `cmd_valid` seen while `cmd_ready` is low starts nothing and leaves `cmd_rdata` unchanged.
- R3: Every frame begins with 32 MDC periods in which MDIO is driven (`mdio_oe`=1) to 1.
- R4: After the preamble the 32 bits of the accepted word go out from bit 31 down to bit 0, one per MDC period. The word layout is [31:30] start (01), [29:28] operation (01 write, 10 read), [27:23] PHY address, [22:18] register address, [17:16] turnaround (10), [15:0] data.
- R5: MDIO only changes while MDC is low; each bit is set at the start of its period and is stable when MDC rises.
- R6: One MDC period lasts 8, 16, 32 or 64 system clocks for `mdc_sel` = 0, 1, 2, 3, high for exactly half of it. The ratio is captured when the command is accepted, and later changes of `mdc_sel` do not affect the running frame.
- R7: When the operation field is 10, MDIO is released (`mdio_oe`=0, `mdio_o` held at 1) for the last 18 bit periods (turnaround and data). `mdio_i` is sampled on the system clock edge on which MDC rises, and the 16 samples replace `cmd_rdata[15:0]`, first sample in bit 15; bits 31:16 keep the written values.
- R8: For any other operation code, MDIO is driven for all 64 bit periods and `cmd_rdata` equals the accepted word.
- R9: `idle` falls on the clock edge that accepts a command and stays low for exactly 64 MDC periods (64 times the ratio in system clocks).
- R10: `cmd_ready` is low while a frame is in flight; a command offered then has no effect on the frame, on its timing or on `cmd_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_en | input | 1 | Management port enable; commands are refused while low |
| mdc_sel | input | 2 | MDC ratio select: 0→8, 1→16, 2→32, 3→64 |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken this cycle |
| cmd_data | input | 32 | Frame word to send |
| cmd_rdata | output | 32 | Held frame word, data field updated by reads |
| idle | output | 1 | High when no frame is in flight |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with its defaults: a 32-bit preamble, a smallest ratio of 8 and a two-bit ratio select. This makes all four ratios, 8 through 64, reachable, and a full frame at the slowest one ends within about 4,100 clocks. That is short enough for random reads and writes at every ratio, plus directed frames that offer a second command and change `mdc_sel` mid-flight, and refused commands with the port disabled.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  // Width of a clause-22 management frame word.
  localparam int FRAME_BITS = 32;
  // Operation code that turns the data bits around.
  localparam logic [1:0] OP_READ = 2'b10;
  // Bit positions the sequencer decodes.
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam int TA_HI   = 17;
  localparam int DATA_HI = 15;

  // Half of an MDC period in system clocks for a ratio select value.
  function automatic int mdc_half(input int min_log2, input int sel);
    return 1 << (min_log2 - 1 + sel);
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_MIN_LOG2 = 3,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_in,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  import mdio_frame_pkg::*;

  localparam int CNT_W = DIV_MIN_LOG2 + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] full_m1;

  always_comb begin
    half_m1  = CNT_W'(mdc_half(DIV_MIN_LOG2, int'(sel_q)) - 1);
    full_m1  = CNT_W'(2 * mdc_half(DIV_MIN_LOG2, int'(sel_q)) - 1);
    rise_evt = run && (cnt == half_m1);
    fall_evt = run && (cnt == full_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt   <= '0;
      mdc   <= 1'b0;
    end else if (start) begin
      sel_q <= sel_in;
      cnt   <= '0;
      mdc   <= 1'b0;
    end else if (run) begin
      cnt <= fall_evt ? '0 : cnt + 1'b1;
      if (rise_evt)      mdc <= 1'b1;
      else if (fall_evt) mdc <= 1'b0;
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cmd_in,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic [31:0] cmd_q,
  output logic        mdio_o,
  output logic        mdio_oe
);
  import mdio_frame_pkg::*;

  localparam int SLOTS     = PRE_LEN + FRAME_BITS;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int IDX_W     = $clog2(FRAME_BITS);
  localparam int REL_FIRST = PRE_LEN + FRAME_BITS - 1 - TA_HI;
  localparam int CAP_FIRST = PRE_LEN + FRAME_BITS - 1 - DATA_HI;

  logic [SLOT_W-1:0] slot;
  logic              rd_q;
  logic [IDX_W-1:0]  off;
  logic [IDX_W-1:0]  bit_idx;
  logic              in_pre;
  logic              released;

  always_comb begin
    off      = IDX_W'(slot - SLOT_W'(PRE_LEN));
    bit_idx  = IDX_W'(FRAME_BITS - 1) - off;
    in_pre   = (slot < SLOT_W'(PRE_LEN));
    released = rd_q && (slot >= SLOT_W'(REL_FIRST));
    mdio_oe  = busy && !released;
    mdio_o   = mdio_oe ? (in_pre ? 1'b1 : cmd_q[bit_idx]) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      slot  <= '0;
      rd_q  <= 1'b0;
      cmd_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      slot  <= '0;
      rd_q  <= (cmd_in[OP_HI:OP_LO] == OP_READ);
      cmd_q <= cmd_in;
    end else if (busy) begin
      if (rise_evt && rd_q && (slot >= SLOT_W'(CAP_FIRST)))
        cmd_q[bit_idx] <= mdio_i;
      if (fall_evt) begin
        if (slot == SLOT_W'(SLOTS - 1)) busy <= 1'b0;
        else                            slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int PRE_LEN      = 32,
  parameter int DIV_MIN_LOG2 = 3,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mgmt_en,
  input  logic [SEL_W-1:0] mdc_sel,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [31:0]      cmd_data,
  output logic [31:0]      cmd_rdata,
  output logic             idle,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic busy;
  logic start;
  logic rise_evt;
  logic fall_evt;

  assign cmd_ready = mgmt_en && !busy;
  assign start     = cmd_valid && cmd_ready;
  assign idle      = !busy;

  mdio_mdc_gen #(
    .DIV_MIN_LOG2(DIV_MIN_LOG2),
    .SEL_W       (SEL_W)
  ) u_mdc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .run     (busy),
    .sel_in  (mdc_sel),
    .mdc     (mdc),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt)
  );

  mdio_frame_seq #(
    .PRE_LEN(PRE_LEN)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd_in  (cmd_data),
    .rise_evt(rise_evt),
    .fall_evt(fall_evt),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .cmd_q   (cmd_rdata),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );
endmodule

// File: rtl/mdio_frame_chk.sv
module mdio_frame_chk #(
  parameter int DIV_MIN_LOG2 = 3,
  parameter int SEL_W        = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] mdc_sel,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [31:0]      cmd_rdata,
  input logic             idle,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  logic [7:0] half_q;
  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      hi_cnt <= '0;
    end else begin
      if (cmd_valid && cmd_ready)
        half_q <= 8'(1 << (DIV_MIN_LOG2 - 1 + int'(mdc_sel)));
      hi_cnt <= mdc ? hi_cnt + 8'd1 : 8'd0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mdio_oe && !mdc));

  assert_refused_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && idle) |=> ($stable(cmd_rdata) && idle));

  assert_mdio_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);

  assert_mdc_high_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == half_q));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !idle);

  assert_no_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !cmd_ready);
endmodule

bind mdio_frame_ctrl mdio_frame_chk #(
  .DIV_MIN_LOG2(DIV_MIN_LOG2),
  .SEL_W       (SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdc_sel  (mdc_sel),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_rdata(cmd_rdata),
  .idle     (idle),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe)
);

// File: tb/sim_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_en = 1'b0;
  logic [1:0]  mdc_sel = 2'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic [31:0] cmd_rdata;
  logic        idle;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mdio_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .mdc_sel(mdc_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_rdata(cmd_rdata), .idle(idle), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // PHY answer for the k-th rising MDC edge of a frame.
  function automatic logic phy_bit(input logic [15:0] d, input int k);
    return (k >= 48) ? d[63-k] : 1'b1;
  endfunction

  function automatic logic [63:0] exp_oe_vec(input logic [31:0] cmd);
    logic [63:0] v;
    for (int k = 0; k < 64; k++) v[k] = !((cmd[29:28] == 2'b10) && k >= 46);
    return v;
  endfunction

  function automatic logic [63:0] exp_o_vec(input logic [31:0] cmd);
    logic [63:0] v;
    logic [63:0] oe;
    oe = exp_oe_vec(cmd);
    for (int k = 0; k < 64; k++) v[k] = (!oe[k] || k < 32) ? 1'b1 : cmd[63-k];
    return v;
  endfunction

  task automatic run_frame(input logic [31:0] cmd, input logic [1:0] sel,
                           input logic [15:0] phy_d, input bit inject);
    logic [63:0] got_o, got_oe;
    logic [31:0] exp_rd;
    int n, cyc, nrise, last_rise;
    bit prev, per_ok, rdy_bad;
    n = 8 << sel;
    got_o = '0; got_oe = '0; nrise = 0; last_rise = 0;
    per_ok = 1; rdy_bad = 0; prev = 0; cyc = 0;
    exp_rd = (cmd[29:28] == 2'b10) ? {cmd[31:16], phy_d} : cmd;
    mdc_sel = sel; cmd_data = cmd; cmd_valid = 1'b1; mdio_i = phy_bit(phy_d, 0);
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    while (!idle && cyc < 10000) begin
      if (inject && cyc == 5) begin
        cmd_valid = 1'b1; cmd_data = ~cmd; mdc_sel = ~sel;
      end else cmd_valid = 1'b0;
      if (cmd_ready) rdy_bad = 1;
      if (mdc && !prev) begin
        if (nrise < 64) begin got_o[nrise] = mdio_o; got_oe[nrise] = mdio_oe; end
        if (nrise > 0 && cyc - last_rise != n) per_ok = 0;
        last_rise = cyc; nrise++;
      end
      if (!mdc && prev) mdio_i = phy_bit(phy_d, nrise);
      prev = mdc; cyc++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; mdc_sel = sel;
    chk("R3 preamble driven ones", {got_oe[31:0], got_o[31:0]}, {32'hFFFF_FFFF, 32'hFFFF_FFFF});
    chk("R4 R5 bit values at MDC rise", got_o, exp_o_vec(cmd));
    chk("R7 R8 drive enable per bit", got_oe, exp_oe_vec(cmd));
    chk("R6 MDC period and rise count", {31'd0, per_ok, 32'(nrise)}, {31'd0, 1'b1, 32'd64});
    chk("R9 busy length", 64'(cyc), 64'(64 * n));
    chk("R7 R8 R10 held word", {32'd0, cmd_rdata}, {32'd0, exp_rd});
    chk("R10 ready low while busy", {63'd0, rdy_bad}, 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {59'd0, idle, mdc, mdio_oe, mdio_o, cmd_ready},
        {59'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    chk("R1 reset word", {32'd0, cmd_rdata}, 64'd0);
    rst_n = 1'b1; mgmt_en = 1'b1;
    @(negedge clk);
    chk("R2 ready when enabled and idle", {63'd0, cmd_ready}, 64'd1);

    // Directed: write at ratio 8, read at ratio 64
    run_frame({2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5C3}, 2'd0, 16'h0000, 1'b0);
    run_frame({2'b01, 2'b10, 5'd31, 5'd1, 2'b10, 16'hFFFF}, 2'd3, 16'h1E87, 1'b0);
    // R10: second command and ratio change during a read frame
    run_frame({2'b01, 2'b10, 5'd0, 5'd2, 2'b10, 16'h0000}, 2'd1, 16'hC0DE, 1'b1);
    // R8: reserved operation code is treated as a driven frame
    run_frame({2'b01, 2'b11, 5'd9, 5'd30, 2'b10, 16'h8001}, 2'd2, 16'h5555, 1'b1);

    // R2: disabled port refuses commands
    held = cmd_rdata;
    mgmt_en = 1'b0; cmd_valid = 1'b1; cmd_data = 32'h5A5A_1234;
    @(negedge clk);
    chk("R2 ready low when disabled", {63'd0, cmd_ready}, 64'd0);
    repeat (20) @(negedge clk);
    chk("R2 refused command no effect", {30'd0, idle, mdc, cmd_rdata}, {30'd0, 1'b1, 1'b0, held});
    cmd_valid = 1'b0; mgmt_en = 1'b1;
    @(negedge clk);

    // Random reads and writes at every ratio
    for (int i = 0; i < 10; i++) begin
      logic [31:0] c;
      c = $urandom;
      c[31:30] = 2'b01;
      c[29:28] = ($urandom % 2) ? 2'b10 : 2'b01;
      run_frame(c, 2'($urandom % 4), 16'($urandom), 1'($urandom % 2));
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule